// File: doc/BRIEF.md
# Write-Only Serial Command Receiver

This block is the two-wire serial slave front end of a control chip that only accepts writes. Its input lines are sampled with a fast system clock, passed through two synchronizer stages and checked for edges. It detects the start and stop conditions on the bus and shifts each byte in with the most significant bit first. It answers to a single hard-wired address byte, 8'b1000_0000, in which the direction bit is zero.

After the address, the block acknowledges every byte and hands it on as an 8-bit command with a valid strobe that lasts one cycle. The command carries its own register select in its upper bits, so the block keeps no register pointer. A read request, or any other address byte, gets no acknowledge, and the block then stays off the bus until the next start. The data line is open-drain and is modelled as a drive-low enable.

Top module: `ctl_i2c_wr_rx`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `sda_drive_low` and `cmd_valid` are 0 and `cmd_byte` is 8'h00.
- R2: A fall of SDA while SCL is high (start) begins reception of an address byte. A rise of SDA while SCL is high (stop) ends the transfer.
- R3: An address byte equal to 8'b1000_0000 (bits sampled on rising SCL, first bit is bit 7) is acknowledged: `sda_drive_low` is 1 while SCL is high during the ninth clock.
- R4: The acknowledge drive turns on only while SCL is low, after the falling edge that ends the eighth bit. It turns off on the falling edge that ends the ninth clock.
- R5: Any other address byte, 8'b1000_0001 (a read) included, gets no acknowledge. Until the next start, no later byte is acknowledged and `cmd_valid` stays 0.
- R6: Each byte after an acknowledged address appears on `cmd_byte`, first bit as bit 7, together with a `cmd_valid` pulse of exactly one system clock. The same byte is acknowledged in its ninth clock. `cmd_byte` changes only together with `cmd_valid`.
- R7: When no transfer is addressed to the block, whether the bus is idle, after a stop, or while SCL toggles without a start, `sda_drive_low` stays 0. A stop releases any active drive.
- R8: A repeated start in the middle of a byte discards the partial byte and restarts address reception.
- R9: Any number of bytes may follow one acknowledged address, and each is delivered and acknowledged in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus (wired-AND) |
| sda_drive_low | output | 1 | 1 pulls the data line low (acknowledge) |
| cmd_byte | output | 8 | Last command byte received |
| cmd_valid | output | 1 | One-cycle strobe when `cmd_byte` holds a new command |

## Verification
The assertions assume a master that follows the bus rules. SDA changes only while SCL is low, except for start and stop. Each SCL level lasts several system clocks, so the synchronized copies show every edge. The bench drives SCL at exactly 16 system clocks per bit and changes SDA one quarter period after a falling edge. It feeds the line back as a wired-AND of the master and `sda_drive_low`, so that the acknowledge the block drives is what the bus carries.

// File: rtl/ctl_i2c_pkg.sv
// Shared definitions for the write-only serial command receiver.
// Assumes: one bus byte is eight bits and the address byte is fixed.
package ctl_i2c_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,      // bus idle or after stop
        ST_ADDR,      // shifting in the address byte
        ST_DATA,      // shifting in a command byte
        ST_ACK_WAIT,  // eighth bit taken, wait for SCL low to drive the ack
        ST_ACK,       // driving the ack through the ninth clock
        ST_SKIP       // not addressed, wait for the next start
    } rx_state_t;
endpackage

// File: rtl/ctl_i2c_line_sync.sv
// Multi-stage synchronizer for one bus line.
// Assumes: STAGES >= 2. Resets to 1 because an idle bus is pulled high.
module ctl_i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_sync
);
    logic [STAGES-1:0] pipe;

    // Shift the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], line_in};
    end

    assign line_sync = pipe[STAGES-1];
endmodule

// File: rtl/ctl_i2c_bus_cond.sv
// Detects SCL edges and start/stop conditions on the synchronized lines.
// Assumes: the inputs are already synchronous and each SCL level lasts
// several clocks. Every output is a one-cycle pulse.
module ctl_i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    // Keep the previous sample of both lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Start or stop needs SCL high in both samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/ctl_i2c_rx_fsm.sv
// Byte engine: matches the address, shifts bytes in most significant bit
// first, emits each command with a one-cycle strobe and drives the acks.
// Assumes: edge and condition pulses from ctl_i2c_bus_cond. Start and
// stop take priority over any bit activity.
module ctl_i2c_rx_fsm
    import ctl_i2c_pkg::*;
#(
    parameter int unsigned       DW        = BYTE_W,
    parameter logic [DW-1:0]     SLAVE_BYTE = 8'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    output logic          sda_drive_low,
    output logic [DW-1:0] cmd_byte,
    output logic          cmd_valid
);
    localparam int unsigned       CNT_W    = $clog2(DW);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DW - 1);

    rx_state_t      state;
    logic [CNT_W-1:0] bit_cnt;
    logic [DW-1:0]  shreg;
    logic [DW-1:0]  full_byte;

    // The byte as it stands with the bit now being sampled.
    assign full_byte = {shreg[DW-2:0], sda_s};

    // Receive sequencing, ack drive and command strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            bit_cnt       <= '0;
            shreg         <= '0;
            sda_drive_low <= 1'b0;
            cmd_byte      <= '0;
            cmd_valid     <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (start_det) begin
                state         <= ST_ADDR;
                bit_cnt       <= '0;
                sda_drive_low <= 1'b0;
            end else if (stop_det) begin
                state         <= ST_IDLE;
                sda_drive_low <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_DATA: begin
                        if (scl_rise) begin
                            shreg <= full_byte;
                            if (bit_cnt == LAST_BIT) begin
                                bit_cnt <= '0;
                                if (state == ST_ADDR) begin
                                    state <= (full_byte == SLAVE_BYTE) ? ST_ACK_WAIT : ST_SKIP;
                                end else begin
                                    cmd_byte  <= full_byte;
                                    cmd_valid <= 1'b1;
                                    state     <= ST_ACK_WAIT;
                                end
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_ACK_WAIT: begin
                        if (scl_fall) begin
                            sda_drive_low <= 1'b1;
                            state         <= ST_ACK;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_drive_low <= 1'b0;
                            state         <= ST_DATA;
                        end
                    end
                    default: begin
                        sda_drive_low <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/ctl_i2c_wr_rx.sv
// Top of the write-only serial command receiver: synchronizers, condition
// detector and byte engine.
// Assumes: clk is at least 16x the SCL rate; the bus carries writes only.
module ctl_i2c_wr_rx #(
    parameter int unsigned   SYNC_STAGES = 2,
    parameter logic [7:0]    SLAVE_BYTE  = 8'h80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_drive_low,
    output logic [7:0] cmd_byte,
    output logic       cmd_valid
);
    logic scl_s;
    logic sda_s;
    logic scl_rise;
    logic scl_fall;
    logic start_det;
    logic stop_det;

    ctl_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in), .line_sync(scl_s)
    );

    ctl_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_in(sda_in), .line_sync(sda_s)
    );

    ctl_i2c_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    ctl_i2c_rx_fsm #(.DW(8), .SLAVE_BYTE(SLAVE_BYTE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .sda_drive_low(sda_drive_low), .cmd_byte(cmd_byte),
        .cmd_valid(cmd_valid)
    );
endmodule

// File: rtl/ctl_i2c_wr_rx_chk.sv
// Property checker for ctl_i2c_wr_rx, bound to the top module.
// Assumes: a master that changes SDA only while SCL is low, apart from
// start and stop.
module ctl_i2c_wr_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_drive_low,
    input logic [7:0] cmd_byte,
    input logic       cmd_valid
);
    // R6: the strobe lasts exactly one cycle.
    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R6: the command output changes only with its strobe.
    assert_byte_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_byte != $past(cmd_byte)) |-> cmd_valid);

    // R4: the ack drive turns on only while SCL is low.
    assert_ack_on_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_s);

    // R4: the ack drive turns off only after a falling SCL edge or a bus condition.
    assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_drive_low) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    // R7: a stop leaves the data line released.
    assert_stop_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_drive_low);

    // R2: a start never leaves the ack drive on.
    assert_start_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_drive_low);
endmodule

bind ctl_i2c_wr_rx ctl_i2c_wr_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_drive_low(sda_drive_low), .cmd_byte(cmd_byte), .cmd_valid(cmd_valid)
);

// File: tb/test_ctl_i2c_wr_rx.sv
// Self-checking bench: master model with wired-AND SDA, sweeps over all
// address bytes and all command bytes.
module test_ctl_i2c_wr_rx;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 4;       // system clocks per quarter SCL period
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_drive_low;
    logic [7:0] cmd_byte;
    logic       cmd_valid;
    logic       sda_bus;

    int checks = 0;
    int failures = 0;
    int cmd_count = 0;
    logic [7:0] last_cmd = 8'h00;
    int run_len = 0;
    int max_run = 0;
    logic bus_free = 1'b1;
    int idle_drive_hits = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = m_sda & ~sda_drive_low;

    ctl_i2c_wr_rx i_ctl_i2c_wr_rx (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .sda_drive_low(sda_drive_low), .cmd_byte(cmd_byte), .cmd_valid(cmd_valid)
    );

    // Monitor outputs away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin
                cmd_count++;
                last_cmd = cmd_byte;
                run_len++;
                if (run_len > max_run) max_run = run_len;
            end else begin
                run_len = 0;
            end
            if (bus_free && sda_drive_low) idle_drive_hits++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
        wq();
    endtask

    task automatic send_bit(input bit b);
        m_sda = b; wq();
        m_scl = 1'b1; wq();
        wq();
        m_scl = 1'b0; wq();
    endtask

    // Ninth clock: returns whether the slave pulled SDA low while SCL high,
    // and whether the drive was released by the end of the next quarter.
    task automatic ack_bit(output bit acked, output bit released);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        acked = (sda_bus == 1'b0);
        wq();
        m_scl = 1'b0; wq();
        released = !sda_drive_low;
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked, output bit released);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        ack_bit(acked, released);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit ack;
        bit rel;
        int cnt0;

        // R1: reset state.
        repeat (4) @(negedge clk);
        check(sda_drive_low == 1'b0, "R1 drive in reset", sda_drive_low, 0);
        check(cmd_valid == 1'b0, "R1 valid in reset", cmd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sda_drive_low == 1'b0 && cmd_valid == 1'b0 && cmd_byte == 8'h00,
              "R1 after release", {sda_drive_low, cmd_valid, cmd_byte}, 0);
        repeat (4) @(negedge clk);

        // R3/R5: sweep every address byte; only 8'h80 is acked.
        for (int a = 0; a < 256; a++) begin
            bus_free = 1'b0;
            bus_start();
            send_byte(8'(a), ack, rel);
            check(ack == (a == 8'h80), (a == 8'h80) ? "R3 addr ack" : "R5 addr nack",
                  ack, (a == 8'h80));
            check(rel, "R4 ack release after address", !rel, 0);
            cnt0 = cmd_count;
            send_byte(8'hA5, ack, rel);
            if (a == 8'h80) begin
                check(ack && cmd_count == cnt0 + 1 && last_cmd == 8'hA5,
                      "R6 byte after match", last_cmd, 8'hA5);
            end else begin
                check(!ack && cmd_count == cnt0, "R5 ignored after mismatch",
                      cmd_count - cnt0, 0);
            end
            bus_stop();
            bus_free = 1'b1;
            wq();
        end

        // R6/R9: one transfer carrying every command byte.
        bus_free = 1'b0;
        bus_start();
        send_byte(8'h80, ack, rel);
        check(ack, "R3 addr ack before sweep", ack, 1);
        for (int d = 0; d < 256; d++) begin
            cnt0 = cmd_count;
            send_byte(8'(d), ack, rel);
            check(ack && rel, "R6 data ack", {ack, rel}, 3);
            check(cmd_count == cnt0 + 1 && last_cmd == 8'(d), "R9 data byte",
                  last_cmd, d);
        end
        bus_stop();
        bus_free = 1'b1;
        wq();

        // R8: repeated start mid-byte discards the partial byte.
        bus_free = 1'b0;
        bus_start();
        send_byte(8'h80, ack, rel);
        cnt0 = cmd_count;
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        bus_start();
        check(cmd_count == cnt0, "R8 no partial byte", cmd_count - cnt0, 0);
        send_byte(8'h80, ack, rel);
        check(ack, "R8 address after restart", ack, 1);
        send_byte(8'h3C, ack, rel);
        check(ack && last_cmd == 8'h3C && cmd_count == cnt0 + 1, "R8 byte after restart",
              last_cmd, 8'h3C);

        // R5/R2: repeated start to a read address, then back to the match.
        bus_start();
        send_byte(8'h81, ack, rel);
        check(!ack, "R5 read address nack", ack, 0);
        cnt0 = cmd_count;
        send_byte(8'h11, ack, rel);
        check(!ack && cmd_count == cnt0, "R5 skip until start", cmd_count - cnt0, 0);
        bus_start();
        send_byte(8'h80, ack, rel);
        check(ack, "R2 start resumes address reception", ack, 1);
        send_byte(8'hC3, ack, rel);
        check(ack && last_cmd == 8'hC3, "R2 byte after new start", last_cmd, 8'hC3);
        bus_stop();
        bus_free = 1'b1;
        wq();

        // R7: clocking without a start after stop draws no ack and no command.
        cnt0 = cmd_count;
        send_byte(8'h80, ack, rel);
        check(!ack && cmd_count == cnt0, "R7 no start, no response", ack, 0);
        m_sda = 1'b1; m_scl = 1'b1;
        repeat (8) @(negedge clk);

        check(idle_drive_hits == 0, "R7 drive while bus free", idle_drive_hits, 0);
        check(max_run == 1, "R6 one-cycle strobe", max_run, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule